// File: doc/BRIEF.md
# Subcarrier Edge-Count Bit Receiver

This block takes in a card-to-reader frame whose length the controller already knows. The frame has no start marker, no stop marker and no length field. The input is a single digital level that an analog comparator with hysteresis produces from the demodulated carrier. A card sending a 1 puts a subcarrier on that level, so the level toggles many times during a bit. A card sending a 0 leaves the level flat. An absent card therefore looks the same as a frame of zeros.

The transmitter signals that its frame has ended, and that event arms the receiver. The receiver then waits a fixed number of ticks before opening its first bit window. Later windows follow back to back. In each window the receiver counts changes of the synchronised input level. A count strictly inside an acceptance band decodes as a 1. Any other count decodes as a 0. Decoded bits fill the result word least significant bit first. If decryption was requested at arming, the word is XORed with a keystream captured at arming. The result is presented with a one-cycle valid pulse, and the tick timer goes back to zero for the next exchange.

Top module: `edge_bit_rx`

## Requirements
- R1: `frame_end_i` arms the receiver when the block is idle and `nbits_i` is between 1 and MAX_BITS. `busy_o` is high from the next cycle. The frame length, decrypt enable and keystream are captured on that same clock edge, so later changes on those inputs have no effect on the frame.
- R2: The first bit window opens WAIT_TICKS (490) ticks after the arming edge. Every window lasts BIT_TICKS (150) ticks, with no gap between windows. `valid_o` is high for exactly one clock, on the cycle after the edge that closes window number `nbits`.
- R3: The input passes through a two-flop synchroniser, and every change of the synchronised level is one edge. A window decodes as 1 when its edge count is greater than 20 and less than 60, and as 0 for any other count, including 0, 20 and 60.
- R4: The per-window edge counter saturates at its all-ones value (63 by default). A window with far more edges than the upper bound therefore always decodes as 0 and never wraps back into the band.
- R5: Window k supplies bit k of `data_o`, with window 0 in bit 0. Bits at positions `nbits` and above are 0.
- R6: When decrypt was captured as 1, `data_o` is the received word XORed with the captured keystream, masked to the frame length. When decrypt was captured as 0, `data_o` is the received word.
- R7: `frame_end_i` has no effect while `busy_o` is high. A `nbits_i` of 0 or above MAX_BITS also leaves the block idle.
- R8: `busy_o` falls on the cycle in which `valid_o` is high, and the tick timer restarts at zero. A new frame can be armed at once and keeps the same timing. `data_o` holds its value until the next valid pulse.
- R9: While reset is asserted, `busy_o`, `valid_o` and `data_o` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_end_i | input | 1 | Pulse from the transmitter marking the end of its frame; arms the receiver |
| nbits_i | input | LEN_W | Number of bits to receive, 1..MAX_BITS |
| crypt_en_i | input | 1 | Apply the keystream to the received word |
| keystream_i | input | MAX_BITS | Keystream bits for the whole frame, LSB for window 0 |
| rx_level_i | input | 1 | Asynchronous thresholded demodulator level |
| busy_o | output | 1 | Frame in progress |
| valid_o | output | 1 | One-cycle pulse: `data_o` carries a new frame |
| data_o | output | MAX_BITS | Received and optionally decrypted frame, LSB first |

## Verification
The assertions assume that the stimulus on `rx_level_i` changes at most once per clock. Each change is held for at least one full cycle, so the synchroniser passes every toggle as a separate edge. They also assume that `nbits_i` is stable during the cycle in which `frame_end_i` is sampled. The stimulus keeps to both rules. It changes the level only on falling clock edges, one toggle per cycle. It starts each burst a few cycles after a window opens, so the two-cycle synchroniser delay never moves an edge into the neighbouring window. It drives the arming fields together with the arming pulse.

// File: rtl/edge_bit_rx_pkg.sv
package edge_bit_rx_pkg;

  typedef enum logic [1:0] {
    RX_IDLE = 2'd0,
    RX_WAIT = 2'd1,
    RX_RECV = 2'd2
  } rx_state_e;

  // True when a count lies strictly between the two bounds.
  function automatic logic in_open_band(input int unsigned value,
                                        input int unsigned lo,
                                        input int unsigned hi);
    return (value > lo) && (value < hi);
  endfunction

endpackage

// File: rtl/ebr_sync.sv
module ebr_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic level_o,
  output logic edge_o
);

  logic [STAGES-1:0] chain_q, chain_d;
  logic              last_q, last_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], async_i};
    last_d  = chain_q[STAGES-1];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      last_q  <= 1'b0;
    end else begin
      chain_q <= chain_d;
      last_q  <= last_d;
    end
  end

  assign level_o = chain_q[STAGES-1];
  assign edge_o  = chain_q[STAGES-1] ^ last_q;

endmodule

// File: rtl/ebr_timer.sv
module ebr_timer #(
  parameter int TICK_DIV   = 1,
  parameter int WAIT_TICKS = 490,
  parameter int BIT_TICKS  = 150
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr_i,
  input  logic phase_bit_i,
  output logic expire_o
);

  localparam int LONGEST = (WAIT_TICKS > BIT_TICKS) ? WAIT_TICKS : BIT_TICKS;
  localparam int TMR_W   = $clog2(LONGEST);

  logic             tick;
  logic [TMR_W-1:0] tcnt_q, tcnt_d;
  logic [TMR_W-1:0] limit;

  generate
    if (TICK_DIV <= 1) begin : g_no_prescale
      assign tick = 1'b1;
    end else begin : g_prescale
      localparam int PRE_W = $clog2(TICK_DIV);
      logic [PRE_W-1:0] pre_q, pre_d;
      logic             pre_wrap;

      assign pre_wrap = (pre_q == PRE_W'(TICK_DIV - 1));

      always_comb begin
        if (clr_i)         pre_d = '0;
        else if (pre_wrap) pre_d = '0;
        else               pre_d = pre_q + PRE_W'(1);
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
      end

      assign tick = pre_wrap;
    end
  endgenerate

  assign limit    = phase_bit_i ? TMR_W'(BIT_TICKS - 1) : TMR_W'(WAIT_TICKS - 1);
  assign expire_o = !clr_i && tick && (tcnt_q == limit);

  always_comb begin
    tcnt_d = tcnt_q;
    if (clr_i)         tcnt_d = '0;
    else if (expire_o) tcnt_d = '0;
    else if (tick)     tcnt_d = tcnt_q + TMR_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) tcnt_q <= '0;
    else        tcnt_q <= tcnt_d;
  end

endmodule

// File: rtl/ebr_edge_cnt.sv
module ebr_edge_cnt
  import edge_bit_rx_pkg::*;
#(
  parameter int LO_EDGES = 20,
  parameter int HI_EDGES = 60,
  parameter int CNT_W    = $clog2(HI_EDGES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en_i,
  input  logic edge_i,
  input  logic close_i,
  output logic bit_o
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  logic [CNT_W-1:0] cnt_q, cnt_d, cnt_inc;

  // Count including this cycle's edge, held at the all-ones value.
  always_comb begin
    cnt_inc = cnt_q;
    if (en_i && edge_i && (cnt_q != CNT_MAX)) cnt_inc = cnt_q + CNT_W'(1);
  end

  always_comb begin
    if (!en_i || close_i) cnt_d = '0;
    else                  cnt_d = cnt_inc;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign bit_o = in_open_band(int'(cnt_inc), LO_EDGES, HI_EDGES);

endmodule

// File: rtl/edge_bit_rx.sv
module edge_bit_rx
  import edge_bit_rx_pkg::*;
#(
  parameter int  MAX_BITS    = 16,
  parameter int  TICK_DIV    = 1,
  parameter int  WAIT_TICKS  = 490,
  parameter int  BIT_TICKS   = 150,
  parameter int  LO_EDGES    = 20,
  parameter int  HI_EDGES    = 60,
  parameter int  SYNC_STAGES = 2,
  localparam int LEN_W       = $clog2(MAX_BITS + 1)
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_end_i,
  input  logic [LEN_W-1:0]    nbits_i,
  input  logic                crypt_en_i,
  input  logic [MAX_BITS-1:0] keystream_i,
  input  logic                rx_level_i,
  output logic                busy_o,
  output logic                valid_o,
  output logic [MAX_BITS-1:0] data_o
);

  localparam int IDX_W = $clog2(MAX_BITS);
  localparam int CNT_W = $clog2(HI_EDGES + 1);

  rx_state_e           state_q, state_d;
  logic [LEN_W-1:0]    len_q, len_d;
  logic                crypt_q, crypt_d;
  logic [MAX_BITS-1:0] ks_q, ks_d;
  logic [IDX_W-1:0]    idx_q, idx_d;
  logic [MAX_BITS-1:0] raw_q, raw_d;
  logic [MAX_BITS-1:0] data_q, data_d;
  logic                valid_q, valid_d;

  logic                len_ok, arm;
  logic [MAX_BITS-1:0] len_mask;
  logic                sync_level, sync_edge;
  logic                expire, win_bit, last_win;
  logic                tmr_clr, in_recv;

  // Input synchroniser and edge detector
  ebr_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rx_level_i),
    .level_o (sync_level),
    .edge_o  (sync_edge)
  );

  // Wait delay and bit windows
  ebr_timer #(
    .TICK_DIV   (TICK_DIV),
    .WAIT_TICKS (WAIT_TICKS),
    .BIT_TICKS  (BIT_TICKS)
  ) u_timer (
    .clk         (clk),
    .rst_n       (rst_n),
    .clr_i       (tmr_clr),
    .phase_bit_i (in_recv),
    .expire_o    (expire)
  );

  // Per-window edge count and bit decision
  ebr_edge_cnt #(
    .LO_EDGES (LO_EDGES),
    .HI_EDGES (HI_EDGES),
    .CNT_W    (CNT_W)
  ) u_cnt (
    .clk     (clk),
    .rst_n   (rst_n),
    .en_i    (in_recv),
    .edge_i  (sync_edge),
    .close_i (expire),
    .bit_o   (win_bit)
  );

  generate
    for (genvar gi = 0; gi < MAX_BITS; gi++) begin : g_mask
      assign len_mask[gi] = (LEN_W'(gi) < nbits_i);
    end
  endgenerate

  assign len_ok   = (nbits_i != '0) && (nbits_i <= LEN_W'(MAX_BITS));
  assign arm      = frame_end_i && (state_q == RX_IDLE) && len_ok;
  assign in_recv  = (state_q == RX_RECV);
  assign tmr_clr  = arm || (state_q == RX_IDLE);
  assign last_win = (LEN_W'(idx_q) == (len_q - LEN_W'(1)));

  always_comb begin
    state_d = state_q;
    len_d   = len_q;
    crypt_d = crypt_q;
    ks_d    = ks_q;
    idx_d   = idx_q;
    raw_d   = raw_q;
    data_d  = data_q;
    valid_d = 1'b0;
    unique case (state_q)
      RX_IDLE: begin
        if (arm) begin
          state_d = RX_WAIT;
          len_d   = nbits_i;
          crypt_d = crypt_en_i;
          ks_d    = keystream_i & len_mask;
          idx_d   = '0;
          raw_d   = '0;
        end
      end
      RX_WAIT: begin
        if (expire) state_d = RX_RECV;
      end
      RX_RECV: begin
        if (expire) begin
          raw_d[idx_q] = win_bit;
          if (last_win) begin
            state_d = RX_IDLE;
            valid_d = 1'b1;
            data_d  = crypt_q ? (raw_d ^ ks_q) : raw_d;
          end else begin
            idx_d = idx_q + IDX_W'(1);
          end
        end
      end
      default: state_d = RX_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= RX_IDLE;
      len_q   <= '0;
      crypt_q <= 1'b0;
      ks_q    <= '0;
      idx_q   <= '0;
      raw_q   <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      state_q <= state_d;
      valid_q <= valid_d;
      if (arm) begin
        len_q   <= len_d;
        crypt_q <= crypt_d;
        ks_q    <= ks_d;
      end
      if (arm || (in_recv && expire)) begin
        idx_q <= idx_d;
        raw_q <= raw_d;
      end
      if (valid_d) data_q <= data_d;
    end
  end

  assign busy_o  = (state_q != RX_IDLE);
  assign valid_o = valid_q;
  assign data_o  = data_q;

  logic unused_level;
  assign unused_level = sync_level;

endmodule

// File: rtl/edge_bit_rx_chk.sv
module edge_bit_rx_chk #(
  parameter int MAX_BITS = 16,
  parameter int LEN_W    = 5
) (
  input logic                clk,
  input logic                rst_n,
  input logic                frame_end_i,
  input logic [LEN_W-1:0]    nbits_i,
  input logic                busy_o,
  input logic                valid_o,
  input logic [MAX_BITS-1:0] data_o,
  input logic [LEN_W-1:0]    len_q
);

  assert_arm_starts_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_end_i && !busy_o && (nbits_i != '0) && (nbits_i <= LEN_W'(MAX_BITS)))
      |=> busy_o);

  assert_valid_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |=> !valid_o);

  assert_upper_bits_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> ((data_o >> len_q) == '0));

  assert_bad_len_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && frame_end_i && ((nbits_i == '0) || (nbits_i > LEN_W'(MAX_BITS))))
      |=> !busy_o);

  assert_busy_falls_R8: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> $fell(busy_o));

  assert_data_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !valid_o |-> $stable(data_o));

endmodule

bind edge_bit_rx edge_bit_rx_chk #(
  .MAX_BITS (MAX_BITS),
  .LEN_W    (LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame_end_i (frame_end_i),
  .nbits_i     (nbits_i),
  .busy_o      (busy_o),
  .valid_o     (valid_o),
  .data_o      (data_o),
  .len_q       (len_q)
);

// File: tb/edge_bit_rx_tb.sv
`timescale 1ns/1ps
module edge_bit_rx_tb;

  localparam int WAIT = 490;
  localparam int BITW = 150;

  typedef struct packed {
    logic [4:0]  nb;
    logic        cr;
    logic [15:0] ks;
    logic [15:0] pat;
    logic [7:0]  n1;
    logic [7:0]  n0;
  } vec_t;

  localparam int NVEC = 7;
  localparam vec_t VEC [NVEC] = '{
    '{5'd6,  1'b0, 16'h0000, 16'h002D, 8'd42,  8'd0},
    '{5'd12, 1'b1, 16'h0A5C, 16'h03C6, 8'd42,  8'd3},
    '{5'd4,  1'b0, 16'h0000, 16'h0005, 8'd21,  8'd20},
    '{5'd4,  1'b0, 16'h0000, 16'h0006, 8'd59,  8'd60},
    '{5'd3,  1'b0, 16'h0000, 16'h0007, 8'd100, 8'd0},
    '{5'd16, 1'b1, 16'hFFFF, 16'h0000, 8'd42,  8'd0},
    '{5'd8,  1'b0, 16'h00FF, 16'h0000, 8'd42,  8'd0}
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        frame_end_i;
  logic [4:0]  nbits_i;
  logic        crypt_en_i;
  logic [15:0] keystream_i;
  logic        rx_level_i;
  logic        busy_o;
  logic        valid_o;
  logic [15:0] data_o;

  int n_checks = 0;
  int n_fail   = 0;
  int valid_cnt = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  edge_bit_rx u_dut (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_end_i (frame_end_i),
    .nbits_i     (nbits_i),
    .crypt_en_i  (crypt_en_i),
    .keystream_i (keystream_i),
    .rx_level_i  (rx_level_i),
    .busy_o      (busy_o),
    .valid_o     (valid_o),
    .data_o      (data_o)
  );

  always @(posedge clk) if (rst_n && valid_o) valid_cnt++;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic bit band(input int n);
    return (n > 20) && (n < 60);
  endfunction

  task automatic run_frame(input int nb, input bit cr, input logic [15:0] ks,
                           input logic [15:0] pat, input int n1, input int n0,
                           input int rearm_c);
    logic [15:0] exp, m;
    int vseen;
    exp = '0;
    for (int i = 0; i < nb; i++) exp[i] = pat[i] ? band(n1) : band(n0);
    m = (nb >= 16) ? 16'hFFFF : ((16'h1 << nb) - 16'h1);
    if (cr) exp = exp ^ (ks & m);
    @(negedge clk);
    frame_end_i = 1'b1; nbits_i = 5'(nb); crypt_en_i = cr; keystream_i = ks;
    @(negedge clk);
    // R1: later changes of the captured fields must not matter
    frame_end_i = 1'b0; keystream_i = ~ks; crypt_en_i = ~cr;
    chk(busy_o === 1'b1, "R1 busy after arm", 32'(busy_o), 32'd1);
    vseen = valid_cnt;
    repeat (WAIT) @(negedge clk);
    for (int k = 0; k < nb; k++) begin
      int n;
      n = pat[k] ? n1 : n0;
      for (int c = 0; c < BITW; c++) begin
        if (c >= 4 && c < 4 + n) rx_level_i = ~rx_level_i;
        if (k == 0 && c == rearm_c) begin
          frame_end_i = 1'b1; nbits_i = 5'd5;
        end
        if (k == nb - 1 && c == BITW - 1)
          chk(valid_o === 1'b0 && busy_o === 1'b1, "R2 no early valid",
              {30'd0, valid_o, busy_o}, 32'd1);
        @(negedge clk);
        frame_end_i = 1'b0;
      end
    end
    chk(valid_o === 1'b1, "R2 valid after last window", 32'(valid_o), 32'd1);
    chk(data_o === exp, "R3 R4 R5 R6 frame data", 32'(data_o), 32'(exp));
    chk(busy_o === 1'b0, "R8 busy falls with valid", 32'(busy_o), 32'd0);
    @(negedge clk);
    chk(valid_o === 1'b0, "R2 valid lasts one cycle", 32'(valid_o), 32'd0);
    chk(valid_cnt == vseen + 1, "R2 one pulse per frame", 32'(valid_cnt - vseen), 32'd1);
    chk(data_o === exp, "R8 data holds", 32'(data_o), 32'(exp));
  endtask

  initial begin
    #1600000;
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    logic [15:0] held;
    rst_n = 1'b0; frame_end_i = 1'b0; nbits_i = '0; crypt_en_i = 1'b0;
    keystream_i = '0; rx_level_i = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy_o === 1'b0 && valid_o === 1'b0 && data_o === 16'h0, "R9 reset state",
        {14'd0, busy_o, valid_o, data_o}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy_o === 1'b0 && valid_o === 1'b0, "R9 idle after reset",
        {30'd0, busy_o, valid_o}, 32'd0);

    // R7: out-of-range lengths leave the block idle
    frame_end_i = 1'b1; nbits_i = 5'd0;
    @(negedge clk);
    frame_end_i = 1'b0;
    chk(busy_o === 1'b0, "R7 zero length ignored", 32'(busy_o), 32'd0);
    frame_end_i = 1'b1; nbits_i = 5'd17;
    @(negedge clk);
    frame_end_i = 1'b0;
    chk(busy_o === 1'b0, "R7 oversize length ignored", 32'(busy_o), 32'd0);

    // Vector table, frames armed back to back (R8 restart)
    for (int v = 0; v < NVEC; v++)
      run_frame(int'(VEC[v].nb), VEC[v].cr, VEC[v].ks, VEC[v].pat,
                int'(VEC[v].n1), int'(VEC[v].n0), -1);

    // R7: an arming pulse mid-frame is ignored
    run_frame(2, 1'b0, 16'h0000, 16'h0001, 42, 0, 50);
    held = data_o;
    repeat (WAIT + 3 * BITW) @(negedge clk);
    chk(busy_o === 1'b0, "R7 no second frame started", 32'(busy_o), 32'd0);
    chk(data_o === held, "R8 data held while idle", 32'(data_o), 32'(held));

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule